// File: doc/BRIEF.md
# Serial Register-Access Slave

This block lets a host microcontroller read and write a 256-location byte space inside the chip over a four-wire synchronous serial link. The host pulls the active-low select line low and sends one address byte, followed by any number of data bytes. Every bit travels least significant bit first. A direction pin chooses the operation. On a write, each completed data byte is stored at the current address. On a read, bytes come back on the serial output. In both cases the address steps after each byte. The step counts only the low four bits, so a burst wraps inside a 16-byte row and never crosses into the next row.

The serial clock, select, data input and direction pin are synchronized into the system clock domain, and the serial clock edges are detected there. The design is a five-state machine:

- **ST_IDLE**: the block is deselected.
- **ST_ADDR**: the address byte is being shifted in.
- **ST_GAP**: the pause between the address byte and the first data byte. The hold output is raised here.
- **ST_WDATA**: write data bytes are being received.
- **ST_RDATA**: read data bytes are being sent.

The transitions are:

- idle to address when select goes low.
- address to gap when the eighth address bit arrives.
- gap to read data after the single cycle that fetches the first byte.
- gap to write data after WAIT_CYC system cycles.
- any state to idle when select goes high.

The memory side is a plain port: an address, write data, a one-cycle write strobe, and combinational read data.

Top module: `ssl_slave`

## Requirements
- R1: While the synchronized select is high, the block returns to idle. In that state sdo sits at 1, hold_o is 0 and no write strobe is issued. Each new select-low period starts again with an address byte.
- R2: Bytes are 8 bits and are shifted least significant bit first. The first byte after select falls is the address, and all later bytes are data.
- R3: sdi is sampled on rising serial clock edges. sdo changes only after falling serial clock edges. The first read bit appears after the falling edge that ends the address byte.
- R4: The direction pin is sampled when the address byte completes. A value of 0 selects write and 1 selects read.
- R5: In a write, each completed data byte produces exactly one single-cycle mem_we pulse. The pulse carries the current address and the received byte, and the address steps on the following cycle.
- R6: In a read, the addressed byte is fetched as soon as the address byte completes and the address then steps. Each further group of 8 clocks returns the byte at the next stepped address.
- R7: During read data bytes, sdi is ignored and no write strobe occurs.
- R8: An address step increments bits 3:0 modulo 16 and leaves bits 7:4 unchanged. For example, 0x3F steps to 0x30.
- R9: hold_o is high only in the gap after the address byte. It stays high for WAIT_CYC (default 4) system cycles on a write and for 1 cycle on a read. It is never high while data bytes are moving.
- R10: A byte left incomplete when select rises is discarded. No write happens, and the next transfer starts with a fresh address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low transfer select |
| sclk | input | 1 | Serial clock from host |
| sdi | input | 1 | Serial data in, LSB first |
| rd_nwr | input | 1 | Direction: 1 read, 0 write |
| sdo | output | 1 | Serial data out, 1 while deselected |
| hold_o | output | 1 | Wait flag in the address-to-data gap |
| mem_addr | output | 8 | Memory address (current address counter) |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Single-cycle memory write strobe |
| mem_rdata | input | 8 | Memory read data for mem_addr |

## Verification
A stuck or mis-stepped address counter shows up at the memory port within a single strobe. The next write lands in the wrong row or column, which the sweep of every address exposes when it compares the full memory image. The same fault appears on sdo as a wrong byte within eight serial clocks of a read. A state machine that stays in, or misses, the gap state shows up immediately as a wrong hold_o pulse length, or as hold_o rising during data. A bit counter that is not cleared at deselect misaligns the very next address byte, so the first byte read back afterwards is wrong.

// File: rtl/ssl_pkg.sv
package ssl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_GAP,
        ST_WDATA,
        ST_RDATA
    } ssl_state_e;

endpackage

// File: rtl/ssl_sync.sv
// Multi-stage synchronizer for a vector of asynchronous inputs.
module ssl_sync #(
    parameter int          W       = 4,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    generate
        if (STAGES == 1) begin : g_single
            logic [W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= RST_VAL;
                else        q <= din;
            end
            assign dout = q;
        end else begin : g_chain
            logic [STAGES-1:0][W-1:0] pipe;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe <= {STAGES{RST_VAL}};
                else        pipe <= {pipe[STAGES-2:0], din};
            end
            assign dout = pipe[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/ssl_addr_step.sv
// Address register with load and a low-field-only wrapping increment.
module ssl_addr_step #(
    parameter int AW     = 8,
    parameter int WRAP_W = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    output logic [AW-1:0] addr
);

    logic [AW-1:0] addr_nxt;

    generate
        if (WRAP_W >= AW) begin : g_full
            localparam logic [AW-1:0] ONE_A = AW'(1);
            assign addr_nxt = addr + ONE_A;
        end else begin : g_split
            localparam logic [WRAP_W-1:0] ONE_W = WRAP_W'(1);
            assign addr_nxt = {addr[AW-1:WRAP_W], addr[WRAP_W-1:0] + ONE_W};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     addr <= '0;
        else if (load)  addr <= load_val;
        else if (step)  addr <= addr_nxt;
    end

endmodule

// File: rtl/ssl_rx_shift.sv
// LSB-first receive shifter with bit counter and byte-complete pulse.
module ssl_rx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift_en,
    input  logic         din,
    output logic         done,
    output logic [W-1:0] byte_q
);

    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            done   <= 1'b0;
            byte_q <= '0;
        end else if (clr) begin
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (shift_en) begin
                byte_q <= {din, byte_q[W-1:1]};
                if (cnt == LAST) begin
                    cnt  <= '0;
                    done <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/ssl_slave.sv
// Serial register-access slave: address byte then auto-stepping data bytes.
module ssl_slave
    import ssl_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int WRAP_W      = 4,
    parameter int SYNC_STAGES = 2,
    parameter int WAIT_CYC    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              rd_nwr,
    output logic              sdo,
    output logic              hold_o,
    output logic [BYTE_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [BYTE_W-1:0] mem_rdata
);

    localparam int GCW = $clog2(WAIT_CYC + 1);
    localparam logic [GCW-1:0] GAP_LAST = GCW'(WAIT_CYC - 1);

    // synchronized inputs: {rd_nwr, sdi, cs_n, sclk}
    logic [3:0] sync_in, sync_out;
    logic       sclk_s, cs_idle, sdi_s, rd_s;
    logic       sclk_d, sclk_rise, sclk_fall;

    assign sync_in = {rd_nwr, sdi, cs_n, sclk};

    ssl_sync #(
        .W      (4),
        .STAGES (SYNC_STAGES),
        .RST_VAL(4'b0010)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (sync_in),
        .dout (sync_out)
    );

    assign {rd_s, sdi_s, cs_idle, sclk_s} = sync_out;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end

    assign sclk_rise = sclk_s & ~sclk_d;
    assign sclk_fall = ~sclk_s & sclk_d;

    ssl_state_e        state, state_n;
    logic              rx_done;
    logic [BYTE_W-1:0] rx_byte;
    logic              rx_clr, rx_en;
    logic              dir_rd;
    logic [GCW-1:0]    gap_cnt;
    logic              tx_load;
    logic [BYTE_W-1:0] tx_sr;
    logic              sdo_q, hold_q, we_q;
    logic [BYTE_W-1:0] wdata_q;
    logic              addr_load, addr_step;

    assign rx_clr = cs_idle || (state == ST_IDLE);
    assign rx_en  = sclk_rise &&
                    ((state == ST_ADDR) || (state == ST_WDATA) || (state == ST_RDATA));

    ssl_rx_shift #(.W(BYTE_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (rx_clr),
        .shift_en(rx_en),
        .din     (sdi_s),
        .done    (rx_done),
        .byte_q  (rx_byte)
    );

    assign tx_load   = !cs_idle &&
                       (((state == ST_GAP) && dir_rd) || ((state == ST_RDATA) && rx_done));
    assign addr_load = !cs_idle && (state == ST_ADDR) && rx_done;
    assign addr_step = we_q || tx_load;

    ssl_addr_step #(.AW(BYTE_W), .WRAP_W(WRAP_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (addr_load),
        .load_val(rx_byte),
        .step    (addr_step),
        .addr    (mem_addr)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // next-state logic
    always_comb begin
        state_n = state;
        if (cs_idle) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  state_n = ST_ADDR;
                ST_ADDR:  if (rx_done) state_n = ST_GAP;
                ST_GAP: begin
                    if (dir_rd)                    state_n = ST_RDATA;
                    else if (gap_cnt == GAP_LAST)  state_n = ST_WDATA;
                end
                ST_WDATA: state_n = ST_WDATA;
                ST_RDATA: state_n = ST_RDATA;
                default:  state_n = ST_IDLE;
            endcase
        end
    end

    // registered outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q  <= 1'b0;
            we_q    <= 1'b0;
            wdata_q <= '0;
            dir_rd  <= 1'b0;
            gap_cnt <= '0;
            sdo_q   <= 1'b1;
            tx_sr   <= '1;
        end else begin
            hold_q  <= (state_n == ST_GAP);
            we_q    <= (state == ST_WDATA) && rx_done && !cs_idle;
            gap_cnt <= (state == ST_GAP) ? gap_cnt + 1'b1 : '0;
            if ((state == ST_WDATA) && rx_done)
                wdata_q <= rx_byte;
            if (addr_load)
                dir_rd <= rd_s;
            if (cs_idle || (state == ST_IDLE)) begin
                sdo_q <= 1'b1;
            end else if (tx_load) begin
                tx_sr <= mem_rdata;
            end else if ((state == ST_RDATA) && sclk_fall) begin
                sdo_q <= tx_sr[0];
                tx_sr <= {1'b1, tx_sr[BYTE_W-1:1]};
            end
        end
    end

    assign sdo       = sdo_q;
    assign hold_o    = hold_q;
    assign mem_we    = we_q;
    assign mem_wdata = wdata_q;

endmodule

// File: rtl/ssl_slave_chk.sv
// Property checker attached to the serial slave.
module ssl_slave_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_idle,
    input logic          hold_o,
    input logic          sdo,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr
);

    // address step after a write keeps the row and wraps the column
    assert_nibble_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (mem_addr[AW-1:4] == $past(mem_addr[AW-1:4])) &&
                   (mem_addr[3:0] == $past(mem_addr[3:0]) + 4'd1));

    // one strobe per byte, never two cycles long
    assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // hold never coincides with data movement
    assert_no_hold_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !hold_o);

    // deselect forces the idle port state
    assert_idle_on_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_idle |=> (!hold_o && sdo && !mem_we));

endmodule

bind ssl_slave ssl_slave_chk #(.AW(BYTE_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_idle (cs_idle),
    .hold_o  (hold_o),
    .sdo     (sdo),
    .mem_we  (mem_we),
    .mem_addr(mem_addr)
);

// File: tb/ssl_slave_bench.sv
`timescale 1ns/1ps
module ssl_slave_bench;

    localparam int HALF     = 8;
    localparam int WAIT_CYC = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       sdi = 1'b0;
    logic       rd_nwr = 1'b0;
    logic       sdo, hold_o, mem_we;
    logic [7:0] mem_addr, mem_wdata, mem_rdata;

    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];

    int checks = 0;
    int fails = 0;
    int hold_total = 0;
    int hold_bad = 0;
    int rd_we_bad = 0;
    int we_total = 0;
    bit in_data = 0;
    bit in_read = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ssl_slave #(.WAIT_CYC(WAIT_CYC)) u_ssl_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sclk     (sclk),
        .sdi      (sdi),
        .rd_nwr   (rd_nwr),
        .sdo      (sdo),
        .hold_o   (hold_o),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_we   (mem_we),
        .mem_rdata(mem_rdata)
    );

    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
        end else begin
            if (mem_we) begin
                mem[mem_addr] <= mem_wdata;
                we_total <= we_total + 1;
                if (in_read) rd_we_bad <= rd_we_bad + 1;
            end
            if (hold_o) begin
                hold_total <= hold_total + 1;
                if (in_data) hold_bad <= hold_bad + 1;
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic bit_cycle(input logic din, output logic dout);
        @(negedge clk);
        sdi = din;
        repeat (HALF) @(negedge clk);
        dout = sdo;
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic xfer_byte(input logic [7:0] b, output logic [7:0] r);
        for (int i = 0; i < 8; i++) bit_cycle(b[i], r[i]);
    endtask

    // begin a transfer and return the number of hold cycles seen after the address
    task automatic start_xfer(input logic rd, input logic [7:0] a, output int hcnt);
        logic [7:0] junk;
        int h0;
        rd_nwr = rd;
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        h0 = hold_total;
        xfer_byte(a, junk);
        repeat (2 * HALF) @(negedge clk);
        hcnt = hold_total - h0;
        in_data = 1'b1;
    endtask

    task automatic end_xfer();
        repeat (2 * HALF) @(negedge clk);
        in_data = 1'b0;
        in_read = 1'b0;
        cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
    endtask

    function automatic logic [7:0] step_addr(input logic [7:0] base, input int k);
        step_addr = {base[7:4], 4'(base[3:0] + 4'(k))};
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int hc;
        int we0;
        logic [7:0] r, a, d, lo;
        logic junkbit;
        for (int i = 0; i < 256; i++) exp_mem[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 reset / idle state
        chk("R1", "reset sdo", int'(sdo), 1);
        chk("R1", "reset hold", int'(hold_o), 0);
        chk("R1", "reset we", int'(mem_we), 0);

        // R4 R5 R8 R9: write every row, starting mid-row, 17 bytes to wrap past start
        for (int hi = 0; hi < 16; hi++) begin
            start_xfer(1'b0, {4'(hi), 4'(hi)}, hc);
            chk("R9", "write hold length", hc, WAIT_CYC);
            for (int k = 0; k < 17; k++) begin
                a = step_addr({4'(hi), 4'(hi)}, k);
                d = 8'(int'(a) * 37 + 11 + ((k == 16) ? 8'h5A : 0));
                exp_mem[a] = d;
                xfer_byte(d, r);
            end
            end_xfer();
            chk("R1", "sdo idle after write", int'(sdo), 1);
        end
        chk("R5", "write strobe count", we_total, 16 * 17);
        for (int i = 0; i < 256; i++)
            chk("R5_R8", $sformatf("memory byte %0h after writes", i), int'(mem[i]), int'(exp_mem[i]));

        // R2 R3 R6 R7 R8 R9: read every row from a shifted column with junk on sdi
        for (int hi = 0; hi < 16; hi++) begin
            lo = 8'(hi * 5);
            start_xfer(1'b1, {4'(hi), lo[3:0]}, hc);
            chk("R9", "read hold length", hc, 1);
            in_read = 1'b1;
            for (int k = 0; k < 17; k++) begin
                a = step_addr({4'(hi), lo[3:0]}, k);
                xfer_byte(~exp_mem[a] ^ 8'(k), r);
                chk("R2_R3_R6", $sformatf("read byte at %0h", a), int'(r), int'(exp_mem[a]));
            end
            end_xfer();
        end
        chk("R7", "strobes during read", rd_we_bad, 0);
        chk("R9", "hold during data", hold_bad, 0);
        for (int i = 0; i < 256; i++)
            chk("R7", $sformatf("memory byte %0h after reads", i), int'(mem[i]), int'(exp_mem[i]));

        // R10: partial data byte is dropped
        we0 = we_total;
        start_xfer(1'b0, 8'h50, hc);
        for (int i = 0; i < 5; i++) bit_cycle(1'b1, junkbit);
        end_xfer();
        chk("R10", "no strobe for partial byte", we_total - we0, 0);
        chk("R10", "memory 50 unchanged", int'(mem[8'h50]), int'(exp_mem[8'h50]));

        // R10 R1: partial address then a fresh read transfer
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < 3; i++) bit_cycle(1'b1, junkbit);
        end_xfer();
        chk("R1", "sdo idle after partial", int'(sdo), 1);
        start_xfer(1'b1, 8'hA7, hc);
        in_read = 1'b1;
        xfer_byte(8'hFF, r);
        chk("R10", "read after partial address", int'(r), int'(exp_mem[8'hA7]));
        xfer_byte(8'h00, r);
        chk("R8", "read step within row", int'(r), int'(exp_mem[8'hA8]));
        end_xfer();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule